// File: doc/BRIEF.md
# Receive Flow Control with Hysteresis

This block drives an active-low request-to-send line for a serial receiver without any help from software. It watches the fill count of the receive FIFO and picks a receive trigger level from one of four level tables. A 2-bit table select chooses the table and a 2-bit trigger select chooses the entry in it. Three tables hold fixed levels. The fourth table takes its trigger level and both of its flow-control thresholds from programmable inputs.

For the fixed tables, the stop and resume points differ from the trigger level itself. The line is released (driven high) when the FIFO count reaches the table entry just above the selected one. It is driven low again when the count falls to the entry just below the selected one. Between those two points the line keeps its value, which gives hysteresis. The top entry of a table uses the full FIFO depth as its stop point, and the bottom entry uses an empty FIFO as its resume point.

Beside the line, the block outputs the selected trigger level and a flag that shows the FIFO holds at least that many bytes.

Top module: `rx_flow_rts`

## Requirements
- R1: `rtsN` is 0 (asserted, sender allowed) while `rstN` is low, whatever the other inputs are, and stays 0 after reset until a stop threshold is reached.
- R2: For `tableSel` 0, 1 and 2, `trigLevel` is the entry chosen by `trigSel` (index 0 to 3) in an ascending table:
  - table 0 holds {1, 16, 32, 56};
  - table 1 holds {4, 16, 32, 48};
  - table 2 holds {8, 16, 56, 60}.
- R3: For `tableSel` 3, `trigLevel` equals `progTrig` and `trigSel` has no effect.
- R4: For tables 0 to 2, the stop threshold is the table entry at index `trigSel`+1, or DEPTH (64) when `trigSel` is 3. On the first clock edge at which `fifoCount` is at or above the stop threshold, `rtsN` becomes 1.
- R5: For tables 0 to 2, the resume threshold is the entry at index `trigSel`-1, or 0 when `trigSel` is 0. On a clock edge at which `fifoCount` is at or below the resume threshold and below the stop threshold, `rtsN` becomes 0.
- R6: While `fifoCount` lies strictly between the resume threshold and the stop threshold, `rtsN` keeps its value.
- R7: For `tableSel` 3, the stop threshold is `haltLevel` and the resume threshold is `resumeLevel`. When a count meets both thresholds, the stop threshold wins and `rtsN` becomes 1.
- R8: `dataAboveTrig` is 1 exactly when `fifoCount` is greater than or equal to `trigLevel`. It follows the inputs combinationally, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoCount | input | 7 | Bytes held in the receive FIFO, 0 to DEPTH |
| tableSel | input | 2 | Level table select; 3 = programmable |
| trigSel | input | 2 | Entry select within a fixed table |
| progTrig | input | 7 | Trigger level for table 3 |
| haltLevel | input | 7 | Stop threshold for table 3 |
| resumeLevel | input | 7 | Resume threshold for table 3 |
| rtsN | output | 1 | Request-to-send, active low, registered |
| trigLevel | output | 7 | Selected receive trigger level |
| dataAboveTrig | output | 1 | FIFO count is at or above the trigger level |

## Verification
The assertions take for granted that `fifoCount` never exceeds the FIFO depth. The ordering check between the resume point, the trigger level and the stop point applies only to the fixed tables, because the programmable thresholds for table 3 may be given in any order. The stimulus keeps every count within 0 to 64. It gives table 3 a stop level above its resume level, except for one directed case that sets the two levels in the wrong order on purpose to exercise the rule that the stop threshold wins.

// File: rtl/rx_flow_pkg.sv
package rx_flow_pkg;

  localparam int NUM_TABLES  = 4;
  localparam int NUM_ENTRIES = 4;
  localparam logic [1:0] TAB_PROG = 2'd3;

  // Compare results handed from the datapath to the control.
  typedef struct packed {
    logic hitHalt;    // count at or above the stop threshold
    logic hitResume;  // count at or below the resume threshold
  } flowStrobe_t;

  // Fixed level tables; the programmable table returns 0 here.
  function automatic int levelOf(input int tab, input int idx);
    int v;
    v = 0;
    case (tab)
      0: case (idx) 0: v = 1; 1: v = 16; 2: v = 32; default: v = 56; endcase
      1: case (idx) 0: v = 4; 1: v = 16; 2: v = 32; default: v = 48; endcase
      2: case (idx) 0: v = 8; 1: v = 16; 2: v = 56; default: v = 60; endcase
      default: v = 0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rx_flow_dp.sv
module rx_flow_dp
  import rx_flow_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] fifoCount,
  input  logic [1:0]    tableSel,
  input  logic [1:0]    trigSel,
  input  logic [CW-1:0] progTrig,
  input  logic [CW-1:0] haltLevel,
  input  logic [CW-1:0] resumeLevel,
  output logic [CW-1:0] trigLevel,
  output logic [CW-1:0] haltTh,
  output logic [CW-1:0] resumeTh,
  output flowStrobe_t   strobe,
  output logic          dataAboveTrig
);

  logic [CW-1:0] lvl [NUM_TABLES][NUM_ENTRIES];

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tab
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      assign lvl[t][i] = CW'(levelOf(t, i));
    end
  end

  always_comb begin
    if (tableSel == TAB_PROG) begin
      trigLevel = progTrig;
      haltTh    = haltLevel;
      resumeTh  = resumeLevel;
    end else begin
      trigLevel = lvl[tableSel][trigSel];
      haltTh    = (trigSel == 2'd3) ? CW'(DEPTH) : lvl[tableSel][trigSel + 2'd1];
      resumeTh  = (trigSel == 2'd0) ? '0 : lvl[tableSel][trigSel - 2'd1];
    end
  end

  assign strobe.hitHalt   = (fifoCount >= haltTh);
  assign strobe.hitResume = (fifoCount <= resumeTh);
  assign dataAboveTrig    = (fifoCount >= trigLevel);

endmodule

// File: rtl/rx_flow_ctl.sv
module rx_flow_ctl
  import rx_flow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  flowStrobe_t strobe,
  output logic        rtsN
);

  // Stop wins over resume; otherwise the line holds.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rtsN <= 1'b0;
    else if (strobe.hitHalt)   rtsN <= 1'b1;
    else if (strobe.hitResume) rtsN <= 1'b0;
  end

endmodule

// File: rtl/rx_flow_rts.sv
module rx_flow_rts
  import rx_flow_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] fifoCount,
  input  logic [1:0]    tableSel,
  input  logic [1:0]    trigSel,
  input  logic [CW-1:0] progTrig,
  input  logic [CW-1:0] haltLevel,
  input  logic [CW-1:0] resumeLevel,
  output logic          rtsN,
  output logic [CW-1:0] trigLevel,
  output logic          dataAboveTrig
);

  flowStrobe_t   strobe;
  logic [CW-1:0] haltTh;
  logic [CW-1:0] resumeTh;

  rx_flow_dp #(.DEPTH(DEPTH)) u_dp (
    .fifoCount    (fifoCount),
    .tableSel     (tableSel),
    .trigSel      (trigSel),
    .progTrig     (progTrig),
    .haltLevel    (haltLevel),
    .resumeLevel  (resumeLevel),
    .trigLevel    (trigLevel),
    .haltTh       (haltTh),
    .resumeTh     (resumeTh),
    .strobe       (strobe),
    .dataAboveTrig(dataAboveTrig)
  );

  rx_flow_ctl u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .rtsN  (rtsN)
  );

endmodule

// File: rtl/rx_flow_chk.sv
module rx_flow_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [CW-1:0] fifoCount,
  input logic [1:0]    tableSel,
  input logic [CW-1:0] trigLevel,
  input logic [CW-1:0] haltTh,
  input logic [CW-1:0] resumeTh,
  input logic          rtsN
);

  // Input assumption: the FIFO never reports more than its depth.
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(DEPTH));

  // R4: reaching the stop threshold releases the line at the next edge.
  a_r4_halt: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount >= haltTh) |=> rtsN);

  // R5: at or below resume and below stop, the line is asserted next.
  a_r5_resume: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount <= resumeTh && fifoCount < haltTh) |=> !rtsN);

  // R6: between the thresholds the line keeps its value.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount > resumeTh && fifoCount < haltTh) |=> $stable(rtsN));

  // R2: fixed tables place the trigger strictly between the two thresholds.
  a_r2_order: assert property (@(posedge clk) disable iff (!rstN)
    (tableSel != 2'd3) |-> (resumeTh < trigLevel && trigLevel < haltTh));

endmodule

bind rx_flow_rts rx_flow_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .fifoCount(fifoCount),
  .tableSel (tableSel),
  .trigLevel(trigLevel),
  .haltTh   (haltTh),
  .resumeTh (resumeTh),
  .rtsN     (rtsN)
);

// File: tb/tb_rx_flow_rts.sv
module tb_rx_flow_rts;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] fifoCount = '0;
  logic [1:0] tableSel = '0;
  logic [1:0] trigSel = '0;
  logic [6:0] progTrig = 7'd20;
  logic [6:0] haltLevel = 7'd40;
  logic [6:0] resumeLevel = 7'd10;
  logic       rtsN;
  logic [6:0] trigLevel;
  logic       dataAboveTrig;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_flow_rts dut (
    .clk          (clk),
    .rstN         (rstN),
    .fifoCount    (fifoCount),
    .tableSel     (tableSel),
    .trigSel      (trigSel),
    .progTrig     (progTrig),
    .haltLevel    (haltLevel),
    .resumeLevel  (resumeLevel),
    .rtsN         (rtsN),
    .trigLevel    (trigLevel),
    .dataAboveTrig(dataAboveTrig)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // {tableSel, trigSel, fifoCount, rtsN, trigLevel, dataAboveTrig}
  localparam int NV = 21;
  localparam logic [19:0] VEC [NV] = '{
    {2'd2, 2'd2, 7'd30, 1'b0, 7'd56, 1'b0},  // R6 hold low
    {2'd2, 2'd2, 7'd59, 1'b0, 7'd56, 1'b1},  // R8 above, R6 below stop
    {2'd2, 2'd2, 7'd60, 1'b1, 7'd56, 1'b1},  // R4 stop at 60
    {2'd2, 2'd2, 7'd30, 1'b1, 7'd56, 1'b0},  // R6 hold high
    {2'd2, 2'd2, 7'd17, 1'b1, 7'd56, 1'b0},  // R6 just above resume
    {2'd2, 2'd2, 7'd16, 1'b0, 7'd56, 1'b0},  // R5 resume at 16
    {2'd2, 2'd2, 7'd40, 1'b0, 7'd56, 1'b0},  // R6
    {2'd0, 2'd0, 7'd15, 1'b0, 7'd1,  1'b1},  // R2 table 0 entry 0
    {2'd0, 2'd0, 7'd16, 1'b1, 7'd1,  1'b1},  // R4 stop at 16
    {2'd0, 2'd0, 7'd1,  1'b1, 7'd1,  1'b1},  // R5 bottom entry resumes only at 0
    {2'd0, 2'd0, 7'd0,  1'b0, 7'd1,  1'b0},  // R5 resume at empty
    {2'd1, 2'd3, 7'd63, 1'b0, 7'd48, 1'b1},  // R4 top entry not yet full
    {2'd1, 2'd3, 7'd64, 1'b1, 7'd48, 1'b1},  // R4 top entry stops at depth
    {2'd1, 2'd3, 7'd33, 1'b1, 7'd48, 1'b0},  // R6
    {2'd1, 2'd3, 7'd32, 1'b0, 7'd48, 1'b0},  // R5 resume at 32
    {2'd3, 2'd1, 7'd39, 1'b0, 7'd20, 1'b1},  // R3 programmable trigger
    {2'd3, 2'd1, 7'd40, 1'b1, 7'd20, 1'b1},  // R7 halt level
    {2'd3, 2'd1, 7'd11, 1'b1, 7'd20, 1'b0},  // R7 hold above resume level
    {2'd3, 2'd1, 7'd10, 1'b0, 7'd20, 1'b0},  // R7 resume level
    {2'd1, 2'd1, 7'd31, 1'b0, 7'd16, 1'b1},  // R2 table 1 entry 1
    {2'd1, 2'd1, 7'd32, 1'b1, 7'd16, 1'b1}   // R4 stop at next entry
  };

  initial begin
    #(8 * 20000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R1: reset state with a full FIFO
    fifoCount = 7'd64;
    repeat (3) @(negedge clk);
    chk("R1 rts in reset", int'(rtsN), 0);
    fifoCount = 7'd0;
    tableSel  = 2'd2;
    trigSel   = 2'd2;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rts after reset", int'(rtsN), 0);

    for (int v = 0; v < NV; v++) begin
      tableSel  = VEC[v][19:18];
      trigSel   = VEC[v][17:16];
      fifoCount = VEC[v][15:9];
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R4/R5/R6 rts vec%0d", v), int'(rtsN), int'(VEC[v][8]));
      chk($sformatf("R2/R3 trigLevel vec%0d", v), int'(trigLevel), int'(VEC[v][7:1]));
      chk($sformatf("R8 above vec%0d", v), int'(dataAboveTrig), int'(VEC[v][0]));
    end

    // R3: trigSel ignored on the programmable table
    tableSel = 2'd3;
    fifoCount = 7'd25;
    for (int s = 0; s < 4; s++) begin
      trigSel = 2'(s);
      #1;
      chk("R3 trigSel ignored", int'(trigLevel), 20);
    end

    // R8: flag follows the count without a clock edge
    tableSel = 2'd2; trigSel = 2'd1; fifoCount = 7'd15;
    #1 chk("R8 comb below", int'(dataAboveTrig), 0);
    fifoCount = 7'd16;
    #1 chk("R8 comb equal", int'(dataAboveTrig), 1);

    // R7: thresholds in the wrong order, stop wins
    @(negedge clk);
    tableSel = 2'd3; haltLevel = 7'd10; resumeLevel = 7'd20; fifoCount = 7'd15;
    @(posedge clk);
    @(negedge clk);
    chk("R7 stop wins", int'(rtsN), 1);

    // R1: asynchronous reset drops the line at once
    rstN = 1'b0;
    #1 chk("R1 async reset", int'(rtsN), 0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule